// File: doc/BRIEF.md
# Indirect Channel Configuration Register File

This block holds the configuration of a two-channel disk controller behind a two-location host window. One location is a byte-wide pointer. Its low bits choose a channel bank and a register index, and its upper bits carry global bus-timing controls. The other location is a word-wide data port. Each read or write of the data port reaches the register that the pointer currently selects.

Each channel has seven registers: a command-block base, a general configuration byte, two read-ahead registers, a control-block base, and two timing bytes. The pointer can step its index on its own after each data access, so software can stream through a whole bank with repeated data-port accesses. Every decoded field of both banks drives its own output.

Host access is a plain strobe interface with no handshake. Each access takes one cycle and is always accepted, so there is no back-pressure. Read data is combinational while the read strobe is high. Writes and index steps take effect at the clock edge that ends the access.

Top module: `idx_cfg_file`

## Requirements
- R1: After reset the pointer reads 0x50. Both banks hold their defaults: command bases 0x1F0 (channel 0) and 0x170 (channel 1), control bases 0x3F6 and 0x376, general config 0x01, data timing 0xF5, command timing 0xDE, and all read-ahead fields 0.
- R2: `host_addr`=0 selects the pointer and `host_addr`=1 selects the data port. A pointer write stores the low byte of `host_wdata`. Pointer bit 5 (burst disable) drives `burst_dis_o` but reads back as 0. Bit 6 drives `posted_ws_o` and bit 4 drives `medium_sel_o`.
- R3: A data access goes to the bank chosen by pointer bit 3 (0 = channel 0, 1 = channel 1) and to the register chosen by pointer bits 2..0. The other bank is left unchanged.
- R4: When pointer bit 7 is 1, every data-port read or write advances the index by one at the end of the access. When bit 7 is 0, the pointer does not change on data accesses.
- R5: An index step from 6 or from 7 goes to 0. Bits 7..3 of the pointer are kept.
- R6: At index 7, a data write changes nothing and a data read returns 0.
- R7: Index 0 (command base) and index 4 (control base) store and return all 16 bits of the data word.
- R8: Index 1 is the general config byte. Its bits are: 7 DMA enable, 6 drive reset, 5 ready-line enable, 4 narrow (8-bit) port, 3 interrupt active-low, 2 power save, 1 bus-master mode, 0 I/O enable. Bit 2 drives `pwr_save_o` but reads back as 0.
- R9: Index 2 (count bits 7..0) and index 3 (bit 7 read-ahead enable, bit 4 mode-4 timing, bits 1..0 count bits 9..8) are write-only and read as 0. `ra_count_o` is the 10-bit joined count.
- R10: Writing index 3 with bit 6 set raises `fifo_clr_o` for exactly the one following cycle. The bit is not stored.
- R11: Indexes 5 and 6 (data and command timing) store only the low byte of a write and read back zero-extended.
- R12: `ide_rst_o` of a channel is high for as long as bit 6 of that channel's general config is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 1 | 0 = pointer, 1 = data port |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid while host_rd is high, 0 otherwise |
| posted_ws_o | output | 1 | Pointer bit 6 |
| burst_dis_o | output | 1 | Pointer bit 5 |
| medium_sel_o | output | 1 | Pointer bit 4 |
| cmd_base_o | output | 2x16 | Command-block base per channel |
| ctl_base_o | output | 2x16 | Control-block base per channel |
| dma_en_o | output | 2 | DMA enable per channel |
| ide_rst_o | output | 2 | Drive reset per channel |
| iordy_en_o | output | 2 | Ready-line enable per channel |
| narrow_o | output | 2 | 8-bit data port per channel |
| irq_low_o | output | 2 | Interrupt active-low per channel |
| pwr_save_o | output | 2 | Power save per channel |
| bm_mode_o | output | 2 | Bus-master mode per channel |
| io_en_o | output | 2 | I/O port enable per channel |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| mode4_o | output | 2 | Mode-4 timing enable per channel |
| ra_count_o | output | 2x10 | Read-ahead count per channel |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per channel |
| data_tim_o | output | 2x8 | Data-port timing per channel |
| cmd_tim_o | output | 2x8 | Command/control timing per channel |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle. They also assume that every strobe lasts one cycle and is judged only at the edge that ends it. The stimulus keeps to this: each task raises exactly one strobe at a falling edge and drops it just after the next rising edge. Reads are sampled in the middle of the strobe cycle, before that edge can step the index.

// File: rtl/idx_cfg_pkg.sv
package idx_cfg_pkg;
  localparam int NUM_CH  = 2;
  localparam int IDX_W   = 3;
  localparam int NUM_IDX = 7;
  localparam int DW      = 16;
  localparam int BW      = 8;
  localparam int CNT_W   = 10;

  typedef struct packed {
    logic [DW-1:0] cmd_base;
    logic [BW-1:0] gen;
    logic [BW-1:0] ra_lo;
    logic          ra_en;
    logic          mode4;
    logic [1:0]    ra_hi;
    logic [DW-1:0] ctl_base;
    logic [BW-1:0] dtim;
    logic [BW-1:0] ctim;
  } bank_t;

  function automatic bank_t bank_default(input int ch);
    bank_t b;
    b          = '0;
    b.cmd_base = (ch == 0) ? 16'h01F0 : 16'h0170;
    b.ctl_base = (ch == 0) ? 16'h03F6 : 16'h0376;
    b.gen      = 8'h01;
    b.dtim     = 8'hF5;
    b.ctim     = 8'hDE;
    return b;
  endfunction
endpackage

// File: rtl/idx_ptr_reg.sv
module idx_ptr_reg #(
  parameter int          PW       = 8,
  parameter int          IW       = 3,
  parameter int          LAST_IDX = 6,
  parameter logic [7:0]  RST_VAL  = 8'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic [PW-1:0] wdata,
  input  logic          data_acc,
  output logic [PW-1:0] ptr_q
);
  logic [IW-1:0] idx_next;

  always_comb begin
    if (ptr_q[IW-1:0] >= IW'(LAST_IDX)) idx_next = '0;
    else                                idx_next = ptr_q[IW-1:0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ptr_q <= RST_VAL[PW-1:0];
    else if (ptr_wr)                   ptr_q <= wdata;
    else if (data_acc && ptr_q[PW-1])  ptr_q[IW-1:0] <= idx_next;
  end

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ptr_wr && ptr_q[PW-1] && ptr_q[IW-1:0] == IW'(LAST_IDX)) |=> (ptr_q[IW-1:0] == '0));
  // R4
  idle_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !data_acc) |=> $stable(ptr_q));
  // R4
  no_step_without_ai_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !ptr_q[PW-1]) |=> $stable(ptr_q));
endmodule

// File: rtl/idx_chan_bank.sv
module idx_chan_bank
  import idx_cfg_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0] wdata,
  output bank_t         regs,
  output logic          fifo_clr,
  output logic [DW-1:0] rdata
);
  localparam bank_t RST_BANK = bank_default(CH);
  localparam int    PS_BIT   = 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs     <= RST_BANK;
      fifo_clr <= 1'b0;
    end else begin
      fifo_clr <= wr_en && (idx == IDX_W'(3)) && wdata[6];
      if (wr_en) begin
        case (idx)
          IDX_W'(0): regs.cmd_base <= wdata;
          IDX_W'(1): regs.gen      <= wdata[BW-1:0];
          IDX_W'(2): regs.ra_lo    <= wdata[BW-1:0];
          IDX_W'(3): begin
            regs.ra_en <= wdata[7];
            regs.mode4 <= wdata[4];
            regs.ra_hi <= wdata[1:0];
          end
          IDX_W'(4): regs.ctl_base <= wdata;
          IDX_W'(5): regs.dtim     <= wdata[BW-1:0];
          IDX_W'(6): regs.ctim     <= wdata[BW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IDX_W'(0): rdata = regs.cmd_base;
      IDX_W'(1): begin
        rdata         = {{(DW-BW){1'b0}}, regs.gen};
        rdata[PS_BIT] = 1'b0;
      end
      IDX_W'(4): rdata = regs.ctl_base;
      IDX_W'(5): rdata = {{(DW-BW){1'b0}}, regs.dtim};
      IDX_W'(6): rdata = {{(DW-BW){1'b0}}, regs.ctim};
      default:   rdata = '0;
    endcase
  end

  // R10
  fifo_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !wr_en) |=> !fifo_clr);
  // R12
  rst_bit_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs.gen[6]) |-> $past(wr_en));
  // R6
  idx7_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(7)) |=> $stable(regs));
endmodule

// File: rtl/idx_cfg_file.sv
module idx_cfg_file
  import idx_cfg_pkg::*;
#(
  parameter logic [7:0] PTR_RST = 8'h50
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_addr,
  input  logic                        host_wr,
  input  logic                        host_rd,
  input  logic [DW-1:0]               host_wdata,
  output logic [DW-1:0]               host_rdata,
  output logic                        posted_ws_o,
  output logic                        burst_dis_o,
  output logic                        medium_sel_o,
  output logic [NUM_CH-1:0][DW-1:0]   cmd_base_o,
  output logic [NUM_CH-1:0][DW-1:0]   ctl_base_o,
  output logic [NUM_CH-1:0]           dma_en_o,
  output logic [NUM_CH-1:0]           ide_rst_o,
  output logic [NUM_CH-1:0]           iordy_en_o,
  output logic [NUM_CH-1:0]           narrow_o,
  output logic [NUM_CH-1:0]           irq_low_o,
  output logic [NUM_CH-1:0]           pwr_save_o,
  output logic [NUM_CH-1:0]           bm_mode_o,
  output logic [NUM_CH-1:0]           io_en_o,
  output logic [NUM_CH-1:0]           ra_en_o,
  output logic [NUM_CH-1:0]           mode4_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] ra_count_o,
  output logic [NUM_CH-1:0]           fifo_clr_o,
  output logic [NUM_CH-1:0][BW-1:0]   data_tim_o,
  output logic [NUM_CH-1:0][BW-1:0]   cmd_tim_o
);
  localparam int CH_BIT  = 3;
  localparam int BST_BIT = 5;

  logic [BW-1:0]             ptr_q;
  logic                      data_acc;
  logic                      data_wr;
  logic [NUM_CH-1:0][DW-1:0] bank_rd;
  logic [DW-1:0]             ptr_rd;

  assign data_acc = host_addr && (host_wr || host_rd);
  assign data_wr  = host_addr && host_wr;

  idx_ptr_reg #(
    .PW(BW), .IW(IDX_W), .LAST_IDX(NUM_IDX - 1), .RST_VAL(PTR_RST)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ptr_wr(!host_addr && host_wr),
    .wdata(host_wdata[BW-1:0]),
    .data_acc(data_acc),
    .ptr_q(ptr_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    bank_t regs;
    idx_chan_bank #(.CH(c)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr && (ptr_q[CH_BIT] == c[0])),
      .idx(ptr_q[IDX_W-1:0]),
      .wdata(host_wdata),
      .regs(regs),
      .fifo_clr(fifo_clr_o[c]),
      .rdata(bank_rd[c])
    );
    assign cmd_base_o[c] = regs.cmd_base;
    assign ctl_base_o[c] = regs.ctl_base;
    assign dma_en_o[c]   = regs.gen[7];
    assign ide_rst_o[c]  = regs.gen[6];
    assign iordy_en_o[c] = regs.gen[5];
    assign narrow_o[c]   = regs.gen[4];
    assign irq_low_o[c]  = regs.gen[3];
    assign pwr_save_o[c] = regs.gen[2];
    assign bm_mode_o[c]  = regs.gen[1];
    assign io_en_o[c]    = regs.gen[0];
    assign ra_en_o[c]    = regs.ra_en;
    assign mode4_o[c]    = regs.mode4;
    assign ra_count_o[c] = {regs.ra_hi, regs.ra_lo};
    assign data_tim_o[c] = regs.dtim;
    assign cmd_tim_o[c]  = regs.ctim;
  end

  assign posted_ws_o  = ptr_q[6];
  assign burst_dis_o  = ptr_q[BST_BIT];
  assign medium_sel_o = ptr_q[4];

  always_comb begin
    ptr_rd          = {{(DW-BW){1'b0}}, ptr_q};
    ptr_rd[BST_BIT] = 1'b0;
  end

  always_comb begin
    if (!host_rd)       host_rdata = '0;
    else if (host_addr) host_rdata = bank_rd[ptr_q[CH_BIT]];
    else                host_rdata = ptr_rd;
  end

  // R9
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr && (ptr_q[IDX_W-1:0] == 3'd2 || ptr_q[IDX_W-1:0] == 3'd3 || ptr_q[IDX_W-1:0] == 3'd7))
      |-> (host_rdata == '0));
  // R2
  burst_bit_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr) |-> (host_rdata[BST_BIT] == 1'b0 && host_rdata[DW-1:BW] == '0));
  // R3
  other_bank_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ptr_q[CH_BIT]) |=> $stable(g_bank[1].regs));
endmodule

// File: tb/idx_cfg_file_test.sv
module idx_cfg_file_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic posted_ws_o, burst_dis_o, medium_sel_o;
  logic [1:0][15:0] cmd_base_o, ctl_base_o;
  logic [1:0] dma_en_o, ide_rst_o, iordy_en_o, narrow_o, irq_low_o, pwr_save_o;
  logic [1:0] bm_mode_o, io_en_o, ra_en_o, mode4_o, fifo_clr_o;
  logic [1:0][9:0] ra_count_o;
  logic [1:0][7:0] data_tim_o, cmd_tim_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idx_cfg_file uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .posted_ws_o(posted_ws_o), .burst_dis_o(burst_dis_o), .medium_sel_o(medium_sel_o),
    .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .dma_en_o(dma_en_o),
    .ide_rst_o(ide_rst_o), .iordy_en_o(iordy_en_o), .narrow_o(narrow_o),
    .irq_low_o(irq_low_o), .pwr_save_o(pwr_save_o), .bm_mode_o(bm_mode_o),
    .io_en_o(io_en_o), .ra_en_o(ra_en_o), .mode4_o(mode4_o), .ra_count_o(ra_count_o),
    .fifo_clr_o(fifo_clr_o), .data_tim_o(data_tim_o), .cmd_tim_o(cmd_tim_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic a, input logic w, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = !w; host_wdata = d;
    #1 q = host_rdata;
    @(posedge clk);
    #1 host_wr = 0; host_rd = 0;
  endtask

  task automatic wptr(input logic [7:0] v);
    logic [15:0] q;
    acc(1'b0, 1'b1, {8'h00, v}, q);
  endtask
  task automatic wdat(input logic [15:0] v);
    logic [15:0] q;
    acc(1'b1, 1'b1, v, q);
  endtask
  task automatic rptr(output logic [15:0] q);
    acc(1'b0, 1'b0, 16'h0, q);
  endtask
  task automatic rdat(output logic [15:0] q);
    acc(1'b1, 1'b0, 16'h0, q);
  endtask

  task automatic t_reset;
    logic [15:0] q;
    rptr(q);
    check("R1 pointer", q, 16'h0050);
    check("R1 cmd bases", {cmd_base_o[1], cmd_base_o[0]}, {16'h0170, 16'h01F0});
    check("R1 ctl bases", {ctl_base_o[1], ctl_base_o[0]}, {16'h0376, 16'h03F6});
    check("R1 timings", {data_tim_o[0], cmd_tim_o[0], data_tim_o[1], cmd_tim_o[1]}, 32'hF5DEF5DE);
    check("R1 io_en", io_en_o, 2'b11);
    check("R1 read-ahead", {ra_count_o[1], ra_count_o[0], ra_en_o}, '0);
  endtask

  task automatic t_ptr_bits;
    logic [15:0] q;
    wptr(8'h20);
    rptr(q);
    check("R2 burst bit reads 0", q, 16'h0000);
    check("R2 outputs", {posted_ws_o, burst_dis_o, medium_sel_o}, 3'b010);
    wptr(8'h50);
    check("R2 outputs restored", {posted_ws_o, burst_dis_o, medium_sel_o}, 3'b101);
  endtask

  task automatic t_bank_select;
    logic [15:0] q;
    wptr(8'h08);
    wdat(16'h1234);
    check("R3 ch1 cmd base", cmd_base_o[1], 16'h1234);
    check("R3 ch0 untouched", cmd_base_o[0], 16'h01F0);
    rdat(q);
    check("R7 cmd base readback", q, 16'h1234);
    wptr(8'h0C);
    wdat(16'hBEEF);
    rdat(q);
    check("R7 ctl base 16 bits", {q, ctl_base_o[1]}, {16'hBEEF, 16'hBEEF});
  endtask

  task automatic t_stream;
    logic [15:0] q;
    wptr(8'h80);
    wdat(16'hA5A0); wdat(16'h008E); wdat(16'h0034); wdat(16'h0092);
    wdat(16'h1376); wdat(16'h0009); wdat(16'h00AB);
    rptr(q);
    check("R5 wrapped after index 6", q, 16'h0080);
    check("R4 streamed bases", {cmd_base_o[0], ctl_base_o[0]}, {16'hA5A0, 16'h1376});
    check("R4 streamed timings", {data_tim_o[0], cmd_tim_o[0]}, 16'h09AB);
    check("R9 count/enable/mode4", {ra_count_o[0], ra_en_o[0], mode4_o[0]}, {10'h234, 1'b1, 1'b1});
    check("R8 fields", {dma_en_o[0], iordy_en_o[0], narrow_o[0], irq_low_o[0], pwr_save_o[0], bm_mode_o[0], io_en_o[0]},
          7'b1001110);
    wptr(8'h01);
    rdat(q);
    check("R8 power-save bit hidden", q, 16'h008A);
    wptr(8'h02); rdat(q);
    check("R9 index 2 reads 0", q, 16'h0);
    wptr(8'h03); rdat(q);
    check("R9 index 3 reads 0", q, 16'h0);
  endtask

  task automatic t_step;
    logic [15:0] q;
    wptr(8'h05);
    rdat(q); rdat(q);
    rptr(q);
    check("R4 no step when bit7 clear", q, 16'h0005);
    wptr(8'h8D);
    rdat(q);
    rptr(q);
    check("R4 step on read", q, 16'h008E);
    wptr(8'h8F);
    rdat(q);
    rptr(q);
    check("R5 step from 7 wraps, upper kept", q, 16'h0088);
  endtask

  task automatic t_idx7;
    logic [15:0] q;
    wptr(8'h07);
    wdat(16'hFFFF);
    rdat(q);
    check("R6 index 7 reads 0", q, 16'h0);
    check("R6 ch0 unchanged", {cmd_base_o[0], ctl_base_o[0], data_tim_o[0], cmd_tim_o[0]},
          {16'hA5A0, 16'h1376, 8'h09, 8'hAB});
    check("R6 ch0 ra unchanged", {ra_count_o[0], ra_en_o[0]}, {10'h234, 1'b1});
  endtask

  task automatic t_timing_byte;
    logic [15:0] q;
    wptr(8'h0D);
    wdat(16'h1233);
    rdat(q);
    check("R11 upper byte dropped", {q, 8'h00, data_tim_o[1]}, {16'h0033, 8'h00, 8'h33});
  endtask

  task automatic t_fifo;
    wptr(8'h0B);
    @(negedge clk);
    host_addr = 1; host_wr = 1; host_wdata = 16'h0040;
    check("R10 no pulse before edge", fifo_clr_o, 2'b00);
    @(posedge clk); #1 host_wr = 0;
    check("R10 pulse after write", fifo_clr_o, 2'b10);
    @(posedge clk); #1;
    check("R10 pulse ends", fifo_clr_o, 2'b00);
    check("R10 not stored, other fields cleared", {ra_en_o[1], mode4_o[1], ra_count_o[1][9:8]}, 4'b0000);
  endtask

  task automatic t_drive_reset;
    wptr(8'h09);
    wdat(16'h0041);
    check("R12 reset asserted", ide_rst_o, 2'b10);
    repeat (3) @(posedge clk);
    #1 check("R12 reset held", ide_rst_o, 2'b10);
    wdat(16'h0001);
    check("R12 reset released", ide_rst_o, 2'b00);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_ptr_bits();
    t_bank_select();
    t_stream();
    t_step();
    t_idx7();
    t_timing_byte();
    t_fifo();
    t_drive_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule